// File: doc/BRIEF.md
# DTMF Steering and Output Latch

This block sits behind a tone-pair classifier. It takes the classifier's per-cycle "tone pair present" flag and its 4-bit key code. From these it produces three things: an early steering flag that follows the classifier, a delayed steering strobe that marks a newly registered digit, and a latched 4-bit code with a drive-enable flag for a shared bus.

A digital up/down guard timer does the duration checks. It counts ticks up while the early flag is high and down while it is low, and it saturates at zero and at the set level. When the timer climbs to the set level, the current code is loaded into the output latch. The strobe then rises a fixed number of cycles later, so the data is stable before the strobe edge. The strobe stays high until the timer has fallen to the release level. Only after that release can another digit be registered. The set level and the set-to-release distance are chosen to lie between 20 ms and 40 ms of ticks. Short tones are therefore ignored, and short drop-outs inside one digit do not split it.

A power-down input clears the timer and both steering outputs but keeps the last latched code.

Top module: `dtmf_steer`

## Requirements
- R1: `earlySteer` equals `sigValid` delayed by one clock. It falls in the cycle after any single-cycle loss of `sigValid`, and it stays low while `powerDown` is high.
- R2: The guard timer saturates at SET_COUNT. After a tone of any length at least SET_COUNT cycles, a pause releases the strobe at the same cycle, SET_COUNT-CLR_COUNT+1 clocks after the pause starts.
- R3: With TICK_DIV=1 and the timer idle at zero, `sigValid` held for at least SET_COUNT cycles registers the code. `dataOut` shows it after clock edge SET_COUNT+1, counted from the first edge that sees `sigValid` high.
- R4: From idle, a tone of SET_COUNT-1 cycles or fewer changes neither `dataOut` nor `delayedSteer`.
- R5: `delayedSteer` rises exactly STROBE_DELAY clocks after the edge that updates `dataOut`.
- R6: `delayedSteer` falls when the timer decays to CLR_COUNT, which is SET_COUNT-CLR_COUNT+1 edges after the pause starts from saturation. A pause of SET_COUNT-CLR_COUNT-1 cycles leaves it high.
- R7: The latch keeps the last registered code until a new registration occurs. A second tone that arrives before release is not latched.
- R8: `dataDrive` follows `outEn`. `dataOut` always carries the latched code, whatever the value of `outEn`.
- R9: `powerDown` clears the timer, `earlySteer` and `delayedSteer` at the next edge and keeps `dataOut`. A following tone of SET_COUNT-1 cycles is then not registered.
- R10: After reset, `earlySteer`, `delayedSteer` and `dataOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigValid | input | 1 | Classifier reports a valid tone pair |
| codeIn | input | CODE_W | Key code from the classifier |
| outEn | input | 1 | Bus drive request |
| powerDown | input | 1 | Clears timer and steering, keeps latch |
| earlySteer | output | 1 | Registered signal-condition flag |
| delayedSteer | output | 1 | Digit-registered strobe |
| dataOut | output | CODE_W | Latched code |
| dataDrive | output | 1 | Bus drive enable |

## Verification
Directed tones placed exactly at SET_COUNT and at SET_COUNT-1 cycles distinguish a correct acceptance threshold from an off-by-one. Pauses of SET_COUNT-CLR_COUNT-1 and SET_COUNT-CLR_COUNT cycles after a saturated tone test the release threshold. Very long tones followed by the same pause show whether the timer saturates or keeps counting. Random codes with tone lengths scattered around the threshold, separated by long pauses, confirm that the latch value and the strobe count follow the acceptance rule over many digits. A power-down in the middle of a tone checks that the timer is cleared while the code is kept.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
  typedef struct packed {
    logic cntUp;
    logic cntDn;
    logic cntClr;
    logic loadCode;
  } guardCtl_t;
endpackage

// File: rtl/dtmf_steer_dp.sv
module dtmf_steer_dp
  import dtmf_steer_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int SET_COUNT = 32,
  parameter int GUARD_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardCtl_t         ctl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              outEn,
  output logic [GUARD_W-1:0] guardLevel,
  output logic [CODE_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam logic [GUARD_W-1:0] SET_LVL = GUARD_W'(SET_COUNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           guardLevel <= '0;
    else if (ctl.cntClr) guardLevel <= '0;
    else if (ctl.cntUp)  guardLevel <= guardLevel + 1'b1;
    else if (ctl.cntDn)  guardLevel <= guardLevel - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= '0;
    else if (ctl.loadCode) dataOut <= codeIn;
  end

  assign dataDrive = outEn;

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    guardLevel <= SET_LVL) else $error("timer above set level"); // R2
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadCode |=> $stable(dataOut)) else $error("latch moved"); // R7
  AST_PD_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cntClr |=> guardLevel == '0) else $error("timer not cleared"); // R9
endmodule

// File: rtl/dtmf_steer_ctrl.sv
module dtmf_steer_ctrl
  import dtmf_steer_pkg::*;
#(
  parameter int SET_COUNT    = 32,
  parameter int CLR_COUNT    = 4,
  parameter int STROBE_DELAY = 3,
  parameter int TICK_DIV     = 1,
  parameter int GUARD_W      = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sigValid,
  input  logic               powerDown,
  input  logic [GUARD_W-1:0] guardLevel,
  output guardCtl_t          ctl,
  output logic               earlySteer,
  output logic               delayedSteer
);
  localparam int DLY_W = $clog2(STROBE_DELAY + 1);
  localparam logic [GUARD_W-1:0] SET_LVL = GUARD_W'(SET_COUNT);
  localparam logic [GUARD_W-1:0] SET_M1  = GUARD_W'(SET_COUNT - 1);
  localparam logic [GUARD_W-1:0] CLR_P1  = GUARD_W'(CLR_COUNT + 1);
  localparam logic [DLY_W-1:0]   DLY_LD  = DLY_W'(STROBE_DELAY);

  logic tick;
  logic held;
  logic setHit, relHit;
  logic [DLY_W-1:0] dlyCnt;

  generate
    if (TICK_DIV == 1) begin : g_noDiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                 divCnt <= '0;
        else if (powerDown)                        divCnt <= '0;
        else if (divCnt == DIV_W'(TICK_DIV - 1))   divCnt <= '0;
        else                                       divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
    end
  endgenerate

  always_comb begin
    setHit       = tick && earlySteer && !held && (guardLevel == SET_M1);
    relHit       = tick && !earlySteer && held && (guardLevel == CLR_P1);
    ctl.cntClr   = powerDown;
    ctl.cntUp    = !powerDown && tick && earlySteer && (guardLevel != SET_LVL);
    ctl.cntDn    = !powerDown && tick && !earlySteer && (guardLevel != '0);
    ctl.loadCode = !powerDown && setHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) earlySteer <= 1'b0;
    else       earlySteer <= sigValid && !powerDown;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     held <= 1'b0;
    else if (powerDown || relHit)  held <= 1'b0;
    else if (setHit)               held <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     dlyCnt <= '0;
    else if (powerDown || relHit)  dlyCnt <= '0;
    else if (setHit)               dlyCnt <= DLY_LD;
    else if (dlyCnt != '0)         dlyCnt <= dlyCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     delayedSteer <= 1'b0;
    else if (powerDown || relHit)  delayedSteer <= 1'b0;
    else if (dlyCnt == DLY_W'(1))  delayedSteer <= 1'b1;
  end

  AST_EARLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !sigValid |=> !earlySteer) else $error("early flag stuck"); // R1
  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(delayedSteer) |-> $past(held)) else $error("strobe without digit"); // R5
  AST_PD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> !earlySteer && !delayedSteer) else $error("pd left steering"); // R9
  AST_STROBE_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    delayedSteer |-> held) else $error("strobe after release"); // R6
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int CODE_W       = 4,
  parameter int SET_COUNT    = 32,
  parameter int CLR_COUNT    = 4,
  parameter int STROBE_DELAY = 3,
  parameter int TICK_DIV     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sigValid,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              outEn,
  input  logic              powerDown,
  output logic              earlySteer,
  output logic              delayedSteer,
  output logic [CODE_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int GUARD_W = $clog2(SET_COUNT + 1);

  guardCtl_t ctl;
  logic [GUARD_W-1:0] guardLevel;

  dtmf_steer_ctrl #(
    .SET_COUNT(SET_COUNT), .CLR_COUNT(CLR_COUNT), .STROBE_DELAY(STROBE_DELAY),
    .TICK_DIV(TICK_DIV), .GUARD_W(GUARD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .powerDown(powerDown),
    .guardLevel(guardLevel), .ctl(ctl), .earlySteer(earlySteer),
    .delayedSteer(delayedSteer)
  );

  dtmf_steer_dp #(
    .CODE_W(CODE_W), .SET_COUNT(SET_COUNT), .GUARD_W(GUARD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .codeIn(codeIn), .outEn(outEn),
    .guardLevel(guardLevel), .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: tb/dtmf_steer_test.sv
module dtmf_steer_test;
  localparam int SETC = 32;
  localparam int CLRC = 4;
  localparam int DLY  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigValid = 1'b0;
  logic [3:0] codeIn = '0;
  logic outEn = 1'b1;
  logic powerDown = 1'b0;
  logic earlySteer, delayedSteer, dataDrive;
  logic [3:0] dataOut;

  int total = 0, bad = 0;
  int cyc = 0;
  int lastDataChg = -1, lastRise = -1, lastFall = -1;
  int riseCount = 0, fallCount = 0;
  logic [3:0] prevData = '0;
  logic prevDly = 1'b0;

  always #10 clk = ~clk;

  dtmf_steer #(.CODE_W(4), .SET_COUNT(SETC), .CLR_COUNT(CLRC),
               .STROBE_DELAY(DLY), .TICK_DIV(1)) uut (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .codeIn(codeIn),
    .outEn(outEn), .powerDown(powerDown), .earlySteer(earlySteer),
    .delayedSteer(delayedSteer), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    if (dataOut !== prevData) lastDataChg = cyc;
    if (delayedSteer && !prevDly) begin lastRise = cyc; riseCount++; end
    if (!delayedSteer && prevDly) begin lastFall = cyc; fallCount++; end
    prevData = dataOut;
    prevDly  = delayedSteer;
  end

  function automatic bit expAccept(int n);
    return n >= SETC;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit lvl, logic [3:0] code, int n, output int t0);
    sigValid = lvl;
    codeIn   = code;
    t0       = cyc;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, p0, r0, f0;
    logic [3:0] expData;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(earlySteer == 0 && delayedSteer == 0, "R10 steering", {earlySteer, delayedSteer}, 0);
    chk(dataOut == 0, "R10 data", dataOut, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 early follows one cycle later, drops on a single-cycle loss
    drive(1, 4'h5, 1, t0);
    chk(earlySteer == 1, "R1 rise", earlySteer, 1);
    drive(0, 4'h5, 1, t0);
    chk(earlySteer == 0, "R1 drop", earlySteer, 0);
    drive(0, 4'h0, SETC + 5, t0);

    // R4 tone one short of threshold
    drive(1, 4'h9, SETC - 1, t0);
    drive(0, 4'h9, SETC + 10, p0);
    chk(dataOut == 0, "R4 data", dataOut, 0);
    chk(riseCount == 0, "R4 strobe", riseCount, 0);

    // R3/R5/R6 tone exactly at threshold
    drive(1, 4'hA, SETC, t0);
    drive(0, 4'hA, SETC + 10, p0);
    chk(dataOut == 4'hA, "R3 data", dataOut, 4'hA);
    chk(lastDataChg == t0 + SETC + 1, "R3 timing", lastDataChg, t0 + SETC + 1);
    chk(lastRise == lastDataChg + DLY, "R5 setup", lastRise, lastDataChg + DLY);
    chk(lastFall == p0 + SETC - CLRC + 1, "R6 release", lastFall, p0 + SETC - CLRC + 1);

    // R6/R7 short pause after saturation, second tone not latched
    r0 = riseCount; f0 = fallCount;
    drive(1, 4'h3, SETC + 50, t0);
    drive(0, 4'h3, SETC - CLRC - 1, p0);
    chk(delayedSteer == 1, "R6 short pause", delayedSteer, 1);
    drive(1, 4'h7, 20, t0);
    drive(0, 4'h7, SETC + 10, p0);
    chk(dataOut == 4'h3, "R7 hold", dataOut, 4'h3);
    chk(riseCount == r0 + 1, "R7 one strobe", riseCount, r0 + 1);
    chk(fallCount == f0 + 1, "R6 one release", fallCount, f0 + 1);

    // R2 saturation: very long tone releases at the same point
    drive(1, 4'h6, SETC + 150, t0);
    drive(0, 4'h6, SETC + 10, p0);
    chk(lastFall == p0 + SETC - CLRC + 1, "R2 saturate", lastFall, p0 + SETC - CLRC + 1);
    chk(dataOut == 4'h6, "R3 long tone", dataOut, 4'h6);

    // R8 drive enable
    outEn = 1'b0;
    @(negedge clk);
    chk(dataDrive == 0, "R8 off", dataDrive, 0);
    chk(dataOut == 4'h6, "R8 data kept", dataOut, 4'h6);
    outEn = 1'b1;
    #1;
    chk(dataDrive == 1, "R8 on", dataDrive, 1);

    // R9 power-down mid-digit
    drive(1, 4'hC, SETC + 10, t0);
    chk(delayedSteer == 1, "R9 pre", delayedSteer, 1);
    powerDown = 1'b1;
    @(negedge clk);
    chk(earlySteer == 0 && delayedSteer == 0, "R9 cleared", {earlySteer, delayedSteer}, 0);
    chk(dataOut == 4'hC, "R9 data kept", dataOut, 4'hC);
    repeat (20) @(negedge clk);
    chk(earlySteer == 0, "R9 early held low", earlySteer, 0);
    powerDown = 1'b0;
    drive(0, 4'hC, 2, p0);
    drive(1, 4'hD, SETC - 1, t0);
    drive(0, 4'hD, SETC + 10, p0);
    chk(dataOut == 4'hC, "R9 timer cleared", dataOut, 4'hC);

    // R3/R4 random lengths around the threshold
    void'($urandom(32'h5eed_1234));
    expData = dataOut;
    for (int i = 0; i < 30; i++) begin
      logic [3:0] c;
      int n;
      c = 4'($urandom_range(0, 15));
      n = SETC - 6 + int'($urandom_range(0, 46));
      r0 = riseCount;
      drive(1, c, n, t0);
      drive(0, c, SETC + 10, p0);
      if (expAccept(n)) expData = c;
      chk(dataOut == expData, expAccept(n) ? "R3 random data" : "R4 random data", dataOut, expData);
      chk(riseCount == r0 + (expAccept(n) ? 1 : 0), "R3 random strobe", riseCount - r0, expAccept(n) ? 1 : 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule